// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C master read and write a bank of 198 byte-wide configuration registers through the two-wire serial bus. It answers to one fixed 7-bit device address, 0x5F. The full address byte 0xBE opens a write transfer and 0xBF opens a read transfer. Registers are reached in the manner of a small serial EEPROM. In a write transfer, the first byte after the address byte loads an internal register pointer, and every later byte is stored at the pointer, which then steps forward. A read transfer streams bytes out starting at the current pointer.

SCL and SDA each enter through a two-flop synchroniser and are then sampled on the system clock. START is seen as SDA falling while SCL is high, and STOP as SDA rising while SCL is high. The block drives SDA only by pulling it low, through an output-enable pin that the pad ring turns into an open-drain driver. The register bank lives inside the block. Every location can be rewritten at any time, including the locations 121 to 131 that the system behind the block uses as an indirect-access window. At reset, register r holds the value r XOR 0x5A.

Top module: `i2c_rf_slave`

## Requirements
- R1: After reset, sda_oe_o is 0, and every register r (0..197) reads back as r XOR 0x5A.
- R2: The address byte 0xBE (write) or 0xBF (read) is acknowledged: sda_oe_o pulls SDA low during the ninth clock.
- R3: Any other address byte is not acknowledged, and sda_oe_o stays 0 for every later bit until the next START. A START after that point is decoded normally.
- R4: In a write transfer, the first byte after the address byte loads the pointer. A value of 198 or above loads pointer 0.
- R5: Each later byte of a write transfer is stored at the pointer and acknowledged, and the pointer then advances by one.
- R6: The pointer advances from 197 to 0, for reads and for writes.
- R7: A read transfer shifts out the register at the pointer, MSB first, and the pointer then advances by one. A master ACK makes the block send the next register. A master NACK leaves SDA released.
- R8: A repeated START keeps the pointer, so a write of only the pointer, then a repeated START, then a read returns data from that pointer.
- R9: The pointer persists across a STOP. A read transfer with no pointer byte continues from where the last transfer left off.
- R10: Registers 121 to 131 are plain read/write storage, like every other register.
- R11: A STOP releases SDA and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, sampling SCL/SDA |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Some properties are checked on every cycle. The pointer always stays inside the 198-entry map. Each register write advances the pointer with wrap-around. SDA is released after STOP and while an unmatched transfer is being ignored. A START always clears the ignore condition, and each decoded address byte leads to either acknowledge or ignore. Only the bench's bus-level scenarios can show what the data looks like on the wire. These cover the reset contents, a full wrapped write and readback sweep, random and current-address reads, clipping of an out-of-range pointer, and a sweep over every foreign device address.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  localparam int unsigned NREG_DEF = 198;
  localparam logic [6:0] DEV_ADDR_DEF = 7'h5F;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACKW, S_ACKH, S_WR, S_RD, S_RDACK, S_RDLD, S_SKIP
  } st_e;

  // pointer step with wrap at the top of the map
  function automatic logic [7:0] ptr_next(input logic [7:0] p, input int unsigned n);
    return (int'(p) == int'(n) - 1) ? 8'd0 : p + 8'd1;
  endfunction

  // pointer bytes beyond the map select register 0
  function automatic logic [7:0] ptr_clip(input logic [7:0] b, input int unsigned n);
    return (int'(b) < int'(n)) ? b : 8'd0;
  endfunction

  function automatic logic [7:0] reset_value(input int unsigned i);
    return 8'(i) ^ 8'h5A;
  endfunction
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rf_regfile.sv
module i2c_rf_regfile
  import i2c_rf_pkg::*;
#(
  parameter int unsigned NREG = NREG_DEF,
  parameter int unsigned DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [7:0]    waddr,
  input  logic [DW-1:0] wdata,
  input  logic [7:0]    raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NREG); i++) mem[i] <= DW'(reset_value(i));
    end else if (we && int'(waddr) < int'(NREG)) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = (int'(raddr) < int'(NREG)) ? mem[raddr] : '0;
endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
  import i2c_rf_pkg::*;
#(
  parameter int unsigned NREG     = NREG_DEF,
  parameter logic [6:0]  DEV_ADDR = DEV_ADDR_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       reg_we,
  output logic [7:0] reg_waddr,
  output logic [7:0] reg_wdata,
  output logic [7:0] ptr,
  output logic       addr_done,
  output logic       addr_match,
  output logic       ignoring
);
  st_e        st;
  logic [2:0] bit_cnt;
  logic [7:0] shreg, txreg;
  logic       rw, first;
  logic [7:0] in_byte;

  assign in_byte    = {shreg[6:0], sda_s};
  assign addr_match = (shreg[6:0] == DEV_ADDR);
  assign addr_done  = (st == S_ADDR) && scl_rise && (bit_cnt == 3'd7);
  assign ignoring   = (st == S_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      txreg     <= '0;
      rw        <= 1'b0;
      first     <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
      ptr       <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        st      <= S_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          S_ADDR: if (scl_rise) begin
            shreg   <= in_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (addr_match) begin
                rw    <= sda_s;
                first <= 1'b1;
                st    <= S_ACKW;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_ACKW: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= S_ACKH;
          end
          S_ACKH: if (scl_fall) begin
            bit_cnt <= '0;
            if (rw) begin
              txreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              st     <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WR;
            end
          end
          S_WR: if (scl_rise) begin
            shreg   <= in_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (first) begin
                ptr   <= ptr_clip(in_byte, NREG);
                first <= 1'b0;
              end else begin
                reg_we    <= 1'b1;
                reg_waddr <= ptr;
                reg_wdata <= in_byte;
                ptr       <= ptr_next(ptr, NREG);
              end
              st <= S_ACKW;
            end
          end
          S_RD: if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= S_RDACK;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              txreg   <= {txreg[6:0], 1'b0};
              sda_oe  <= ~txreg[6];
            end
          end
          S_RDACK: if (scl_rise) begin
            ptr <= ptr_next(ptr, NREG);
            st  <= sda_s ? S_SKIP : S_RDLD;
          end
          S_RDLD: if (scl_fall) begin
            txreg   <= rd_data;
            sda_oe  <= ~rd_data[7];
            bit_cnt <= '0;
            st      <= S_RD;
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_rf_slave.sv
module i2c_rf_slave
  import i2c_rf_pkg::*;
#(
  parameter int unsigned NREG     = NREG_DEF,
  parameter logic [6:0]  DEV_ADDR = DEV_ADDR_DEF,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       reg_we, addr_done, addr_match, ignoring;
  logic [7:0] reg_waddr, reg_wdata, ptr, rd_data;

  i2c_rf_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rf_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe_o), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .ptr(ptr),
    .addr_done(addr_done), .addr_match(addr_match), .ignoring(ignoring)
  );

  i2c_rf_regfile #(.NREG(NREG), .DW(8)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr),
    .wdata(reg_wdata), .raddr(ptr), .rdata(rd_data)
  );
endmodule

// File: rtl/i2c_rf_slave_chk.sv
module i2c_rf_slave_chk
  import i2c_rf_pkg::*;
#(
  parameter int unsigned NREG = NREG_DEF
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       start_det,
  input logic       stop_det,
  input logic       ignoring,
  input logic       reg_we,
  input logic [7:0] reg_waddr,
  input logic [7:0] ptr,
  input logic       addr_done,
  input logic       addr_match
);
  // R4, R6: pointer never leaves the map
  p_ptr_in_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < int'(NREG));

  // R5, R6: each stored byte advances the pointer, with wrap
  p_write_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (ptr == ptr_next(reg_waddr, NREG)));

  p_write_in_map_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> int'(reg_waddr) < int'(NREG));

  // R11: STOP releases the line
  p_stop_releases_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R3: ignored transfer keeps SDA released
  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  p_start_rearms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !ignoring);

  p_foreign_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_match) |=> ignoring);

  // R2: own address goes on to acknowledge, not ignore
  p_own_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && addr_match) |=> !ignoring);
endmodule

bind i2c_rf_slave i2c_rf_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .start_det(start_det),
  .stop_det(stop_det), .ignoring(ignoring), .reg_we(reg_we),
  .reg_waddr(reg_waddr), .ptr(ptr), .addr_done(addr_done),
  .addr_match(addr_match)
);

// File: tb/i2c_rf_slave_tb.sv
module i2c_rf_slave_tb;
  localparam int Q = 4;
  localparam int N = 198;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_rf_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  function automatic logic [7:0] rv(input int r);
    return 8'(r) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] wv(input int r);
    return 8'((r * 7 + 3) % 256);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic i_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    ack = ~sda_line; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic recv(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl_m = 1'b1; w(Q); b[i] = sda_line; w(Q); scl_m = 1'b0;
    end
    w(Q); sda_m = ~mack; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    sda_m = 1'b1;
  endtask

  // random read of cnt bytes starting at p, expected via sel (0 reset, 1 written)
  task automatic rd_from(input int p, input int cnt, input int sel);
    logic a;
    logic [7:0] b, e;
    i_start();
    send(8'hBE, a); chk(a, "R2 write addr ack", a, 1);
    send(8'(p), a); chk(a, "R4 pointer ack", a, 1);
    i_start();
    send(8'hBF, a); chk(a, "R8 read addr after rstart", a, 1);
    for (int k = 0; k < cnt; k++) begin
      int r;
      r = (p + k) % N;
      recv(b, k < cnt - 1);
      e = (sel == 0) ? rv(r) : wv(r);
      if (sel == 0) chk(b == e, "R1 reset value", b, e);
      else if (r >= 121 && r <= 131) chk(b == e, "R10 window reg", b, e);
      else chk(b == e, "R7 readback", b, e);
    end
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    i_stop();
    chk(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    w(5); rst_n = 1'b1; w(3);
    chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

    // R1, R6: reset contents, wrapping one past the end
    rd_from(0, N + 1, 0);

    // R5, R6, R10: full write sweep starting near the top
    i_start();
    send(8'hBE, a); chk(a, "R2 addr ack", a, 1);
    send(8'd190, a); chk(a, "R4 ptr ack", a, 1);
    for (int k = 0; k < N; k++) begin
      int r;
      r = (190 + k) % N;
      send(wv(r), a); chk(a, "R5 data ack", a, 1);
    end
    i_stop();

    // R7, R8, R6, R10: readback across the wrap
    rd_from(100, N, 1);

    // R9: pointer persists across STOP, current-address reads
    i_start(); send(8'hBE, a); send(8'd50, a); i_stop();
    i_start(); send(8'hBF, a); chk(a, "R2 read addr ack", a, 1);
    recv(b, 1'b0); chk(b == wv(50), "R9 current read", b, wv(50)); i_stop();
    i_start(); send(8'hBF, a);
    recv(b, 1'b0); chk(b == wv(51), "R9 pointer advanced", b, wv(51)); i_stop();

    // R6: write wrap 197 -> 0
    i_start(); send(8'hBE, a); send(8'd197, a);
    send(8'h11, a); send(8'h22, a); i_stop();
    i_start(); send(8'hBE, a); send(8'd197, a); i_start(); send(8'hBF, a);
    recv(b, 1'b1); chk(b == 8'h11, "R6 reg197", b, 8'h11);
    recv(b, 1'b0); chk(b == 8'h22, "R6 wrapped reg0", b, 8'h22); i_stop();

    // R4: pointer byte beyond the map selects 0
    i_start(); send(8'hBE, a); send(8'd200, a);
    send(8'h3C, a); chk(a, "R5 ack after clipped ptr", a, 1); i_stop();
    i_start(); send(8'hBE, a); send(8'd0, a); i_start(); send(8'hBF, a);
    recv(b, 1'b0); chk(b == 8'h3C, "R4 clip to 0", b, 8'h3C); i_stop();
    i_start(); send(8'hBE, a); send(8'd1, a); i_start(); send(8'hBF, a);
    recv(b, 1'b0); chk(b == wv(1), "R4 reg1 untouched", b, wv(1)); i_stop();

    // R3: foreign address, then silence until START, then re-armed
    i_start(); send(8'h40, a); chk(!a, "R3 nack foreign", a, 0);
    send(8'h00, a); chk(!a, "R3 stays released", a, 0);
    send(8'hBE, a); chk(!a, "R3 own addr mid-ignore", a, 0);
    i_start(); send(8'hBE, a); chk(a, "R3 rearmed by start", a, 1);
    i_stop();

    // R3: sweep every other device address
    for (int ad = 0; ad < 128; ad++) begin
      if (ad != 7'h5F) begin
        i_start();
        send({7'(ad), 1'(ad % 2)}, a);
        chk(!a, "R3 foreign sweep", a, 0);
        i_stop();
      end
    end
    chk(sda_oe == 1'b0, "R11 idle at end", sda_oe, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule